// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small, fully associative cache of page mappings. Each slot stores a process identifier, a virtual page number, a physical frame number, a valid bit and a write-permission bit. A lookup gives a process identifier, a virtual address and a read/write flag. One cycle later the block reports hit, miss or permission fault, together with the physical address. The physical address is the cached frame number with the 12-bit page offset appended unchanged.

Slots are tagged with a process identifier, so mappings from several processes can sit side by side. A context switch then needs no clearing. A global flush is still provided for software that prefers to clear the cache on a switch. A selective purge removes a single mapping when its permissions are reduced. After a miss, the page table walker elsewhere in the chip refills the block through a fill port. The fill goes to a slot that already holds the same mapping. If there is none, it goes to the lowest-numbered free slot. If the cache is full, it goes to a round-robin victim.

Top module: `pid_tlb`

## Requirements
- R1: After reset every slot is invalid, so respValid, respHit and respFault are low and every lookup misses.
- R2: respValid is lookupValid delayed by exactly one clock. The result reflects the slot contents that were present before that same clock edge updated them.
- R3: A lookup hits only on a valid slot whose process identifier and virtual page number (lookupVaddr bits 31:12) both equal the request. A slot with the same page but a different process identifier does not match.
- R4: On a hit, respPaddr equals the slot's frame number in bits 29:12 and lookupVaddr bits 11:0 in bits 11:0. When respHit is low, respPaddr is zero.
- R5: A write lookup (lookupWrite=1) that matches a slot filled with fillWritable=0 gives respFault=1 and respHit=0. A read of the same slot hits, and a read never faults.
- R6: flushReq invalidates every slot from the next cycle onward.
- R7: purgeValid invalidates only the slot that matches purgePid and purgeVpn. Other slots, including the same page under another process, remain valid.
- R8: If a flush or a matching purge arrives in the same cycle as a lookup, the invalidation wins and that lookup misses.
- R9: A fill with no matching slot goes to the lowest-indexed invalid slot. When all 16 slots are valid, it overwrites the slot at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, each time it is used.
- R10: A fill presented in the same cycle as a flush or a purge is discarded.
- R11: A fill whose process identifier and page already match a valid slot replaces that slot, so a single purge afterwards leaves no stale copy.
- R12: A fill takes effect on the clock edge that accepts it. A lookup in that same cycle still misses, and a lookup in the following cycle hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupPid | input | 8 | Requesting process identifier |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupWrite | input | 1 | 1 for a write access, 0 for a read |
| fillValid | input | 1 | Refill strobe |
| fillPid | input | 8 | Process identifier of the new mapping |
| fillVpn | input | 20 | Virtual page number of the new mapping |
| fillPfn | input | 18 | Physical frame number of the new mapping |
| fillWritable | input | 1 | Write permission of the new mapping |
| purgeValid | input | 1 | Selective invalidate strobe |
| purgePid | input | 8 | Process identifier to purge |
| purgeVpn | input | 20 | Virtual page number to purge |
| flushReq | input | 1 | Invalidate all slots |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Translation found and permitted |
| respFault | output | 1 | Translation found but the write is not permitted |
| respPaddr | output | 30 | Translated physical address |

## Verification
The round-robin replacement path is the hardest one to reach from the ports. It only runs when all sixteen slots are valid and the incoming mapping matches none of them. The bench first flushes the cache, fills every slot with distinct pages of one process and then adds two extra pages, checking by lookups that slots 0 and 1 were evicted. It then purges one slot to open a hole and confirms that the next fill lands in the hole. A further fill must evict the slot where the pointer was left. Same-cycle collisions of lookup, fill, purge and flush are driven deliberately to check the priority rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic flushAll;
    logic purgeOn;
    logic fillOn;
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flushReq,
  input  logic               purgeValid,
  input  logic               fillValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  output tlbStrobes_t        strobes,
  output logic [IDX_W-1:0]   fillIdx
);
  logic             anyHit, anyFree, useRr;
  logic [IDX_W-1:0] hitIdx, freeIdx, rrPtr;

  // invalidations outrank fills
  always_comb begin
    strobes.flushAll = flushReq;
    strobes.purgeOn  = purgeValid;
    strobes.fillOn   = fillValid && !flushReq && !purgeValid;
  end

  // priority encoders: lowest index wins
  always_comb begin
    anyHit  = 1'b0;
    anyFree = 1'b0;
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillHitVec[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!validVec[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    useRr   = !anyHit && !anyFree;
    fillIdx = anyHit ? hitIdx : (anyFree ? freeIdx : rrPtr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (strobes.fillOn && useRr) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlbStrobes_t            strobes,
  input  logic [IDX_W-1:0]       fillIdx,
  input  logic                   lookupValid,
  input  logic [PID_W-1:0]       lookupPid,
  input  logic [VPN_W+OFF_W-1:0] lookupVaddr,
  input  logic                   lookupWrite,
  input  logic [PID_W-1:0]       fillPid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic                   fillWritable,
  input  logic [PID_W-1:0]       purgePid,
  input  logic [VPN_W-1:0]       purgeVpn,
  output logic [ENTRIES-1:0]     validVec,
  output logic [ENTRIES-1:0]     fillHitVec,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respFault,
  output logic [PFN_W+OFF_W-1:0] respPaddr
);
  logic [ENTRIES-1:0] entValid, entWr, lookMatch, purgeMatch, fillMatch, liveVec;
  logic [PID_W-1:0]   entPid [ENTRIES];
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PFN_W-1:0]   entPfn [ENTRIES];
  logic [VPN_W-1:0]   lookVpn;
  logic [PFN_W-1:0]   pfnSel;
  logic               hitAny, wrSel;

  assign lookVpn = lookupVaddr[VPN_W+OFF_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookMatch[g]  = entValid[g] && entPid[g] == lookupPid && entVpn[g] == lookVpn;
    assign purgeMatch[g] = entValid[g] && entPid[g] == purgePid  && entVpn[g] == purgeVpn;
    assign fillMatch[g]  = entValid[g] && entPid[g] == fillPid   && entVpn[g] == fillVpn;
  end

  assign validVec   = entValid;
  assign fillHitVec = fillMatch;
  // same-cycle invalidation hides the slot from the lookup
  assign liveVec = lookMatch
                 & ~(purgeMatch & {ENTRIES{strobes.purgeOn}})
                 & {ENTRIES{!strobes.flushAll}};

  always_comb begin
    pfnSel = '0;
    wrSel  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (liveVec[i]) begin
        pfnSel = pfnSel | entPfn[i];
        wrSel  = wrSel | entWr[i];
      end
    end
    hitAny = |liveVec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entValid <= '0;
      entWr    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entPid[i] <= '0;
        entVpn[i] <= '0;
        entPfn[i] <= '0;
      end
    end else if (strobes.flushAll) begin
      entValid <= '0;
    end else if (strobes.purgeOn) begin
      entValid <= entValid & ~purgeMatch;
    end else if (strobes.fillOn) begin
      entValid[fillIdx] <= 1'b1;
      entWr[fillIdx]    <= fillWritable;
      entPid[fillIdx]   <= fillPid;
      entVpn[fillIdx]   <= fillVpn;
      entPfn[fillIdx]   <= fillPfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && hitAny && (!lookupWrite || wrSel);
      respFault <= lookupValid && hitAny && lookupWrite && !wrSel;
      respPaddr <= (lookupValid && hitAny && (!lookupWrite || wrSel))
                   ? {pfnSel, lookupVaddr[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
  import tlb_pkg::*;
#(
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lookupValid,
  input  logic [PID_W-1:0]       lookupPid,
  input  logic [VPN_W+OFF_W-1:0] lookupVaddr,
  input  logic                   lookupWrite,
  input  logic                   fillValid,
  input  logic [PID_W-1:0]       fillPid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic                   fillWritable,
  input  logic                   purgeValid,
  input  logic [PID_W-1:0]       purgePid,
  input  logic [VPN_W-1:0]       purgeVpn,
  input  logic                   flushReq,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respFault,
  output logic [PFN_W+OFF_W-1:0] respPaddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbStrobes_t        strobes;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] validVec, fillHitVec;

  tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flushReq(flushReq), .purgeValid(purgeValid),
    .fillValid(fillValid), .validVec(validVec), .fillHitVec(fillHitVec),
    .strobes(strobes), .fillIdx(fillIdx)
  );

  tlb_datapath #(
    .PID_W(PID_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W),
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .fillIdx(fillIdx),
    .lookupValid(lookupValid), .lookupPid(lookupPid), .lookupVaddr(lookupVaddr),
    .lookupWrite(lookupWrite), .fillPid(fillPid), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillWritable(fillWritable), .purgePid(purgePid),
    .purgeVpn(purgeVpn), .validVec(validVec), .fillHitVec(fillHitVec),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respPaddr(respPaddr)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int OFF_W   = 12,
  parameter int PA_W    = 30,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookupValid,
  input logic               lookupWrite,
  input logic [OFF_W-1:0]   lookupOffset,
  input logic               flushReq,
  input logic [ENTRIES-1:0] validVec,
  input logic               respValid,
  input logic               respHit,
  input logic               respFault,
  input logic [PA_W-1:0]    respPaddr
);
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> respValid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !respValid);
  assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> (!respHit || respPaddr[OFF_W-1:0] == $past(lookupOffset)));
  assert_miss_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !respHit |-> respPaddr == '0);
  assert_hit_fault_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(respHit && respFault));
  assert_read_never_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !lookupWrite) |=> !respFault);
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> validVec == '0);
  assert_flush_beats_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq && lookupValid) |=> (!respHit && !respFault));
endmodule

bind pid_tlb tlb_checker #(.OFF_W(OFF_W), .PA_W(PFN_W + OFF_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
  .lookupOffset(lookupVaddr[OFF_W-1:0]), .flushReq(flushReq), .validVec(validVec),
  .respValid(respValid), .respHit(respHit), .respFault(respFault), .respPaddr(respPaddr)
);

// File: tb/pid_tlb_tb.sv
module pid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [7:0]  lookupPid = '0;
  logic [31:0] lookupVaddr = '0;
  logic        fillValid = 1'b0, fillWritable = 1'b0;
  logic [7:0]  fillPid = '0;
  logic [19:0] fillVpn = '0;
  logic [17:0] fillPfn = '0;
  logic        purgeValid = 1'b0;
  logic [7:0]  purgePid = '0;
  logic [19:0] purgeVpn = '0;
  logic        flushReq = 1'b0;
  logic        respValid, respHit, respFault;
  logic [29:0] respPaddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        fault;
    logic [29:0] pa;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  always #10ns clk = ~clk;

  pid_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupPid(lookupPid),
    .lookupVaddr(lookupVaddr), .lookupWrite(lookupWrite), .fillValid(fillValid),
    .fillPid(fillPid), .fillVpn(fillVpn), .fillPfn(fillPfn), .fillWritable(fillWritable),
    .purgeValid(purgeValid), .purgePid(purgePid), .purgeVpn(purgeVpn),
    .flushReq(flushReq), .respValid(respValid), .respHit(respHit),
    .respFault(respFault), .respPaddr(respPaddr)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic lookup(input logic [7:0] pid, input logic [31:0] va, input logic wr,
                        input logic eh, input logic ef, input logic [17:0] epfn,
                        input string tag);
    expItem_t it;
    lookupValid = 1'b1; lookupPid = pid; lookupVaddr = va; lookupWrite = wr;
    it.hit = eh; it.fault = ef; it.pa = eh ? {epfn, va[11:0]} : 30'd0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic fill(input logic [7:0] pid, input logic [19:0] vpn,
                      input logic [17:0] pfn, input logic wr);
    fillValid = 1'b1; fillPid = pid; fillVpn = vpn; fillPfn = pfn; fillWritable = wr;
  endtask

  task automatic purge(input logic [7:0] pid, input logic [19:0] vpn);
    purgeValid = 1'b1; purgePid = pid; purgeVpn = vpn;
  endtask

  task automatic step();
    @(negedge clk);
    lookupValid = 1'b0; fillValid = 1'b0; purgeValid = 1'b0; flushReq = 1'b0;
  endtask

  // monitor: pop the expected item for each response
  always @(negedge clk) begin
    if (rst_n && respValid) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual respValid=1 expected 0");
      end else begin
        expItem_t e;
        e = sbq.pop_front();
        if (respHit !== e.hit || respFault !== e.fault || respPaddr !== e.pa) begin
          errors++;
          $display("FAIL %s: actual hit=%0b fault=%0b pa=%h expected hit=%0b fault=%0b pa=%h",
                   e.tag, respHit, respFault, respPaddr, e.hit, e.fault, e.pa);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual run still busy expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (respValid !== 1'b0 || respHit !== 1'b0 || respFault !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %0b%0b%0b expected 000", respValid, respHit, respFault);
    end
    rst_n = 1'b1;
    step();
    lookup(8'd1, 32'h12345678, 1'b0, 0, 0, 0, "R1 empty after reset"); step();
    // idle cycle: no response expected
    step();
    checks++;
    if (respValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle: actual respValid=%0b expected 0", respValid);
    end

    // fill and same-cycle lookup
    fill(8'd1, 20'h12345, 18'h0ABC, 1'b1);
    lookup(8'd1, 32'h12345678, 1'b0, 0, 0, 0, "R12 same-cycle fill misses"); step();
    lookup(8'd1, 32'h12345678, 1'b0, 1, 0, 18'h0ABC, "R12 hit after fill"); step();
    lookup(8'd1, 32'h12345FFF, 1'b1, 1, 0, 18'h0ABC, "R4 offset passes, writable"); step();
    lookup(8'd2, 32'h12345678, 1'b0, 0, 0, 0, "R3 other pid misses"); step();
    lookup(8'd1, 32'h12346678, 1'b0, 0, 0, 0, "R3 other page misses"); step();

    // read-only mapping for pid 2 on the same page
    fill(8'd2, 20'h12345, 18'h0DEF, 1'b0); step();
    lookup(8'd2, 32'h12345010, 1'b0, 1, 0, 18'h0DEF, "R3 pid2 hit own frame"); step();
    lookup(8'd2, 32'h12345010, 1'b1, 0, 1, 0, "R5 write to read-only faults"); step();
    lookup(8'd1, 32'h12345010, 1'b1, 1, 0, 18'h0ABC, "R5 pid1 write still hits"); step();

    // refill of an existing mapping
    fill(8'd1, 20'h12345, 18'h01111, 1'b1); step();
    lookup(8'd1, 32'h12345222, 1'b0, 1, 0, 18'h01111, "R11 refill replaces frame"); step();
    purge(8'd1, 20'h12345); step();
    lookup(8'd1, 32'h12345222, 1'b0, 0, 0, 0, "R11 R7 purge leaves no stale copy"); step();
    lookup(8'd2, 32'h12345222, 1'b0, 1, 0, 18'h0DEF, "R7 other pid survives purge"); step();

    // purge collides with lookup
    purge(8'd2, 20'h12345);
    lookup(8'd2, 32'h12345222, 1'b0, 0, 0, 0, "R8 purge beats lookup"); step();
    lookup(8'd2, 32'h12345222, 1'b0, 0, 0, 0, "R7 purged entry gone"); step();

    // fills dropped under invalidation
    purge(8'd9, 20'h00077); fill(8'd3, 20'h00001, 18'h00033, 1'b1); step();
    lookup(8'd3, 32'h00001000, 1'b0, 0, 0, 0, "R10 fill dropped with purge"); step();
    flushReq = 1'b1; fill(8'd3, 20'h00001, 18'h00033, 1'b1); step();
    lookup(8'd3, 32'h00001000, 1'b0, 0, 0, 0, "R10 fill dropped with flush"); step();

    // flush
    fill(8'd3, 20'h00002, 18'h00022, 1'b1); step();
    lookup(8'd3, 32'h00002004, 1'b0, 1, 0, 18'h00022, "R12 new mapping hits"); step();
    flushReq = 1'b1;
    lookup(8'd3, 32'h00002004, 1'b0, 0, 0, 0, "R8 flush beats lookup"); step();
    lookup(8'd3, 32'h00002004, 1'b0, 0, 0, 0, "R6 flushed entry gone"); step();

    // fill every slot, then force round-robin eviction
    for (int i = 0; i < 16; i++) begin
      fill(8'd5, 20'(i), 18'h00100 + 18'(i), 1'b1); step();
    end
    fill(8'd5, 20'h00020, 18'h00200, 1'b1); step();
    fill(8'd5, 20'h00021, 18'h00201, 1'b1); step();
    lookup(8'd5, 32'h00000ABC, 1'b0, 0, 0, 0, "R9 slot0 evicted first"); step();
    lookup(8'd5, 32'h00001ABC, 1'b0, 0, 0, 0, "R9 slot1 evicted second"); step();
    lookup(8'd5, 32'h00002ABC, 1'b0, 1, 0, 18'h00102, "R9 slot2 kept"); step();
    lookup(8'd5, 32'h0000FABC, 1'b0, 1, 0, 18'h0010F, "R9 slot15 kept"); step();
    lookup(8'd5, 32'h00020ABC, 1'b0, 1, 0, 18'h00200, "R9 first extra page"); step();
    lookup(8'd5, 32'h00021ABC, 1'b0, 1, 0, 18'h00201, "R9 second extra page"); step();
    purge(8'd5, 20'h00005); step();
    fill(8'd5, 20'h00022, 18'h00202, 1'b1); step();
    fill(8'd5, 20'h00023, 18'h00203, 1'b1); step();
    lookup(8'd5, 32'h00022ABC, 1'b0, 1, 0, 18'h00202, "R9 hole refilled"); step();
    lookup(8'd5, 32'h00002ABC, 1'b0, 0, 0, 0, "R9 pointer evicts slot2"); step();
    lookup(8'd5, 32'h00023ABC, 1'b0, 1, 0, 18'h00203, "R9 evicting fill hits"); step();
    lookup(8'd5, 32'h00003ABC, 1'b0, 1, 0, 18'h00103, "R9 slot3 kept"); step();
    lookup(8'd5, 32'h00005ABC, 1'b0, 0, 0, 0, "R7 purged slot stays gone"); step();

    step(); step();
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule